// File: doc/BRIEF.md
# Loopback Bit-Error Scorer with Clock-Compensation Symbol Removal

This block sits on the pattern-generator side of a serial link test. The generator keeps a reference copy of the decoded symbols it sends out. The device under test loops those symbols back. Either end of the link may insert or delete clock-compensation (SKP) ordered-set symbols to absorb the rate difference between the two clocks. The block takes both decoded symbol streams and removes every SKP symbol from each one. It pairs the remaining symbols in arrival order and scores how many bits differ. Because SKP symbols are removed, adding or dropping them never shows up as an error.

Each stream passes through its own SKP filter into a small FIFO. A pair is compared in a cycle where both FIFOs hold a symbol. The block reports three things:

- a saturating count of differing bits;
- a count of compared pairs;
- a sticky flag that says alignment is lost.

The flag is set by a long run of mismatching pairs or by a FIFO overflow. A synchronous clear input resets all three outputs without touching the FIFO contents.

Top module: `lbk_err_counter`

## Requirements
- R1: A symbol whose K flag is 1 and whose data equals SKP_CODE (default 8'h3C) is discarded on either input and never takes part in a comparison. A symbol with the same data but K flag 0, or with K flag 1 and other data, is compared normally.
- R2: Non-SKP valid symbols of each stream are kept in arrival order. One pair, the oldest symbol of each stream, is compared per cycle whenever both streams hold a symbol. The compared count rises by one per pair.
- R3: For every compared pair, the error count rises by the number of differing bits across the 9-bit symbol {K flag, data[7:0]}.
- R4: The error count saturates at all ones (2^ERR_W-1) and never wraps.
- R5: LOSS_RUN (default 16) consecutive mismatching pairs set the loss-of-alignment flag. Any matching pair restarts the run from zero.
- R6: A non-SKP symbol that arrives while its stream's FIFO holds DEPTH (default 8) entries, in a cycle with no pair compared, is dropped and sets the loss-of-alignment flag. Symbols already stored are kept.
- R7: The loss-of-alignment flag stays set until the clear input is high at a clock edge. Clear zeroes the error count, the compared count, the mismatch run and the flag. Clear takes priority over any increment or set in the same cycle and leaves the FIFO contents as they are.
- R8: After reset, the error count, the compared count and the flag are zero.
- R9: A pair whose later symbol is accepted at clock edge n shows up in the counters after edge n+1, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of counters and flag |
| ref_valid_i | input | 1 | Reference symbol valid |
| ref_k_i | input | 1 | Reference symbol is a control character |
| ref_data_i | input | 8 | Reference symbol data |
| rx_valid_i | input | 1 | Looped-back symbol valid |
| rx_k_i | input | 1 | Looped-back symbol is a control character |
| rx_data_i | input | 8 | Looped-back symbol data |
| err_cnt_o | output | ERR_W | Saturating count of differing bits |
| cmp_cnt_o | output | CMP_W | Count of compared pairs |
| align_lost_o | output | 1 | Sticky loss-of-alignment flag |

## Verification
The hardest states to reach are those where SKP symbols land at different places in the two streams, so that the FIFOs drift apart in fill level, and then overflow on purpose. Random stimulus inserts SKP symbols independently into each stream and lets one stream run up to four symbols ahead of the other. A cycle-level model in the bench tracks both queues exactly. Directed sequences then feed one stream alone past its depth, walk the mismatch run to one short of the limit and reset it with a match, and place a clear in the same cycle as a compare.

// File: rtl/lbk_pkg.sv
`timescale 1ns/1ps
package lbk_pkg;
    localparam int SYM_DATA_W = 8;
    localparam int SYM_W      = SYM_DATA_W + 1;

    typedef struct packed {
        logic                  k;
        logic [SYM_DATA_W-1:0] data;
    } sym_t;
endpackage

// File: rtl/lbk_skp_fifo.sv
`timescale 1ns/1ps
module lbk_skp_fifo
    import lbk_pkg::*;
#(
    parameter int                    DEPTH    = 8,
    parameter logic [SYM_DATA_W-1:0] SKP_CODE = 8'h3C
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         in_valid_i,
    input  sym_t                         in_sym_i,
    input  logic                         pop_i,
    output logic                         avail_o,
    output sym_t                         head_o,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic                         ovf_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        sym_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     is_skp, push, full, accept;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d   = st_q;
        is_skp = in_sym_i.k && (in_sym_i.data == SKP_CODE);
        push   = in_valid_i && !is_skp;
        full   = (st_q.cnt == CNT_W'(DEPTH));
        accept = push && (!full || pop_i);
        ovf_o  = push && full && !pop_i;
        if (pop_i) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        if (accept) begin
            st_d.mem[st_q.wr] = in_sym_i;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        case ({accept, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail_o = (st_q.cnt != '0);
    assign head_o  = st_q.mem[st_q.rd];
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/lbk_score.sv
`timescale 1ns/1ps
module lbk_score
    import lbk_pkg::*;
#(
    parameter int ERR_W    = 16,
    parameter int CMP_W    = 24,
    parameter int LOSS_RUN = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             pop_i,
    input  sym_t             ref_sym_i,
    input  sym_t             rx_sym_i,
    input  logic             ovf_i,
    output logic [ERR_W-1:0] err_cnt_o,
    output logic [CMP_W-1:0] cmp_cnt_o,
    output logic             lost_o
);
    localparam int               RUN_W   = $clog2(LOSS_RUN + 1);
    localparam int               POP_W   = $clog2(SYM_W + 1);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic [CMP_W-1:0] cmp;
        logic [RUN_W-1:0] run;
        logic             lost;
    } score_st_t;

    score_st_t        st_d, st_q;
    logic [POP_W-1:0] diff_bits;
    logic [ERR_W:0]   err_sum;
    logic [RUN_W-1:0] run_inc;

    function automatic logic [POP_W-1:0] bit_count(input logic [SYM_W-1:0] v);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < SYM_W; i++) begin
            n = n + POP_W'(v[i]);
        end
        return n;
    endfunction

    always_comb begin
        st_d      = st_q;
        diff_bits = bit_count(ref_sym_i ^ rx_sym_i);
        err_sum   = {1'b0, st_q.err} + (ERR_W+1)'(diff_bits);
        run_inc   = (st_q.run == RUN_W'(LOSS_RUN)) ? st_q.run : st_q.run + RUN_W'(1);
        if (pop_i) begin
            st_d.cmp = st_q.cmp + CMP_W'(1);
            st_d.err = err_sum[ERR_W] ? ERR_MAX : err_sum[ERR_W-1:0];
            if (diff_bits != '0) begin
                st_d.run = run_inc;
                if (run_inc == RUN_W'(LOSS_RUN)) begin
                    st_d.lost = 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
        end
        if (ovf_i) begin
            st_d.lost = 1'b1;
        end
        if (clr_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_cnt_o = st_q.err;
    assign cmp_cnt_o = st_q.cmp;
    assign lost_o    = st_q.lost;
endmodule

// File: rtl/lbk_err_counter.sv
`timescale 1ns/1ps
module lbk_err_counter
    import lbk_pkg::*;
#(
    parameter int                    DEPTH    = 8,
    parameter int                    ERR_W    = 16,
    parameter int                    CMP_W    = 24,
    parameter int                    LOSS_RUN = 16,
    parameter logic [SYM_DATA_W-1:0] SKP_CODE = 8'h3C
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  clr_i,
    input  logic                  ref_valid_i,
    input  logic                  ref_k_i,
    input  logic [SYM_DATA_W-1:0] ref_data_i,
    input  logic                  rx_valid_i,
    input  logic                  rx_k_i,
    input  logic [SYM_DATA_W-1:0] rx_data_i,
    output logic [ERR_W-1:0]      err_cnt_o,
    output logic [CMP_W-1:0]      cmp_cnt_o,
    output logic                  align_lost_o
);
    localparam int N_LANE = 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [N_LANE-1:0] lane_valid, lane_avail, lane_ovf;
    sym_t              lane_in   [N_LANE];
    sym_t              lane_head [N_LANE];
    logic [CNT_W-1:0]  lane_cnt  [N_LANE];
    logic              pair_pop;

    assign lane_valid = {rx_valid_i, ref_valid_i};
    assign lane_in[0] = {ref_k_i, ref_data_i};
    assign lane_in[1] = {rx_k_i, rx_data_i};
    assign pair_pop   = &lane_avail;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        lbk_skp_fifo #(
            .DEPTH    (DEPTH),
            .SKP_CODE (SKP_CODE)
        ) u_fifo (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .in_valid_i (lane_valid[g]),
            .in_sym_i   (lane_in[g]),
            .pop_i      (pair_pop),
            .avail_o    (lane_avail[g]),
            .head_o     (lane_head[g]),
            .cnt_o      (lane_cnt[g]),
            .ovf_o      (lane_ovf[g])
        );
    end

    lbk_score #(
        .ERR_W    (ERR_W),
        .CMP_W    (CMP_W),
        .LOSS_RUN (LOSS_RUN)
    ) u_score (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr_i),
        .pop_i     (pair_pop),
        .ref_sym_i (lane_head[0]),
        .rx_sym_i  (lane_head[1]),
        .ovf_i     (|lane_ovf),
        .err_cnt_o (err_cnt_o),
        .cmp_cnt_o (cmp_cnt_o),
        .lost_o    (align_lost_o)
    );
endmodule

// File: rtl/lbk_err_counter_chk.sv
`timescale 1ns/1ps
module lbk_err_counter_chk
    import lbk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ERR_W = 16,
    parameter int CMP_W = 24
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       clr_i,
    input logic                       pop_i,
    input logic [$clog2(DEPTH+1)-1:0] ref_cnt_i,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt_i,
    input logic [ERR_W-1:0]           err_cnt_i,
    input logic [CMP_W-1:0]           cmp_cnt_i,
    input logic                       lost_i
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    assert_fifo_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_cnt_i <= CNT_W'(DEPTH)) && (rx_cnt_i <= CNT_W'(DEPTH)));

    assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (err_cnt_i == '0) && (cmp_cnt_i == '0) && !lost_i);

    assert_lost_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lost_i && !clr_i) |=> lost_i);

    assert_err_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (err_cnt_i >= $past(err_cnt_i)));

    assert_err_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ({1'b0, err_cnt_i} <= ({1'b0, $past(err_cnt_i)} + (ERR_W+1)'(SYM_W))));

    assert_idle_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !pop_i) |=> ($stable(err_cnt_i) && $stable(cmp_cnt_i)));

    assert_cmp_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && pop_i) |=> (cmp_cnt_i == CMP_W'($past(cmp_cnt_i) + CMP_W'(1))));
endmodule

bind lbk_err_counter lbk_err_counter_chk #(
    .DEPTH (DEPTH),
    .ERR_W (ERR_W),
    .CMP_W (CMP_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .pop_i     (pair_pop),
    .ref_cnt_i (lane_cnt[0]),
    .rx_cnt_i  (lane_cnt[1]),
    .err_cnt_i (err_cnt_o),
    .cmp_cnt_i (cmp_cnt_o),
    .lost_i    (align_lost_o)
);

// File: tb/tb_lbk_err_counter.sv
`timescale 1ns/1ps
module tb_lbk_err_counter;
    localparam int         DEPTH    = 8;
    localparam int         ERR_W    = 10;
    localparam int         CMP_W    = 24;
    localparam int         LOSS_RUN = 16;
    localparam logic [7:0] SKP      = 8'h3C;
    localparam int         ERR_MAX  = (1 << ERR_W) - 1;
    localparam logic [8:0] SKP_SYM  = {1'b1, SKP};

    logic clk = 1'b0, rst_ni = 1'b0, clr = 1'b0;
    logic rv = 1'b0, rk = 1'b0, xv = 1'b0, xk = 1'b0;
    logic [7:0] rd = '0, xd = '0;
    logic [ERR_W-1:0] err;
    logic [CMP_W-1:0] cmp;
    logic lost;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [8:0] qa[$], qb[$];
    int exp_err = 0, exp_cmp = 0, exp_run = 0;
    bit exp_lost = 0;

    always #2.5 clk = ~clk;

    lbk_err_counter #(
        .DEPTH(DEPTH), .ERR_W(ERR_W), .CMP_W(CMP_W), .LOSS_RUN(LOSS_RUN), .SKP_CODE(SKP)
    ) dut (
        .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr),
        .ref_valid_i(rv), .ref_k_i(rk), .ref_data_i(rd),
        .rx_valid_i(xv), .rx_k_i(xk), .rx_data_i(xd),
        .err_cnt_o(err), .cmp_cnt_o(cmp), .align_lost_o(lost)
    );

    function automatic bit is_skp(logic [8:0] s);
        return s[8] && (s[7:0] == SKP);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        check({req, " error count"}, err, exp_err);
        check({req, " compared count"}, cmp, exp_cmp);
        check({req, " alignment flag"}, lost, exp_lost);
    endtask

    // one clock: drive, let the edge happen, advance the reference model
    task automatic cyc(bit av, logic [8:0] as, bit bv, logic [8:0] bs, bit c = 0);
        bit pop;
        logic [8:0] x;
        int n;
        rv = av; rk = as[8]; rd = as[7:0];
        xv = bv; xk = bs[8]; xd = bs[7:0];
        clr = c;
        @(posedge clk);
        pop = (qa.size() > 0) && (qb.size() > 0);
        if (pop) begin
            x = qa.pop_front() ^ qb.pop_front();
            n = $countones(x);
            exp_cmp++;
            exp_err = (exp_err + n > ERR_MAX) ? ERR_MAX : exp_err + n;
            if (n != 0) begin
                if (exp_run < LOSS_RUN) exp_run++;
                if (exp_run == LOSS_RUN) exp_lost = 1;
            end else begin
                exp_run = 0;
            end
        end
        if (av && !is_skp(as)) begin
            if (qa.size() < DEPTH) qa.push_back(as); else exp_lost = 1;
        end
        if (bv && !is_skp(bs)) begin
            if (qb.size() < DEPTH) qb.push_back(bs); else exp_lost = 1;
        end
        if (c) begin
            exp_err = 0; exp_cmp = 0; exp_run = 0; exp_lost = 0;
        end
        @(negedge clk);
        rv = 0; xv = 0; clr = 0;
    endtask

    task automatic idle(int n);
        repeat (n) cyc(0, '0, 0, '0);
    endtask

    // random streams with independent SKP insertion and bit flips on the loop side
    task automatic rand_run(int nsym, int flip_den);
        logic [8:0] pay[$], rxl[$];
        int ia = 0, ib = 0;
        for (int i = 0; i < nsym; i++) begin
            logic [8:0] s, f;
            s = {($urandom % 8) == 0, 8'($urandom)};
            if (is_skp(s)) s[8] = 1'b0;
            pay.push_back(s);
            f = s;
            if (($urandom % flip_den) == 0) begin
                f = s ^ (9'($urandom) | 9'h001);
                if (is_skp(f)) f = s;
            end
            rxl.push_back(f);
        end
        while (ia < nsym || ib < nsym) begin
            bit av = 0, bv = 0;
            logic [8:0] as = '0, bs = '0;
            if (($urandom % 10) == 0) begin av = 1; as = SKP_SYM; end
            else if (ia < nsym && (ia - ib) < 4 && ($urandom % 5) != 0) begin
                av = 1; as = pay[ia]; ia++;
            end
            if (($urandom % 10) == 0) begin bv = 1; bs = SKP_SYM; end
            else if (ib < nsym && (ib - ia) < 4 && ($urandom % 5) != 0) begin
                bv = 1; bs = rxl[ib]; ib++;
            end
            cyc(av, as, bv, bs);
        end
        idle(DEPTH + 2);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_state("R8 reset");
        rst_ni = 1'b1;
        idle(2);
        check_state("R8 after release");

        // R9: counters follow one edge after the completing symbol is accepted
        cyc(1, 9'h011, 0, '0);
        cyc(0, '0, 1, 9'h011);
        check("R9 not yet counted", cmp, 0);
        idle(1);
        check("R9 counted next edge", cmp, 1);

        // R1: SKPs stripped on both sides; near-SKP symbols compared normally
        cyc(1, SKP_SYM, 1, 9'h055);
        cyc(1, SKP_SYM, 1, SKP_SYM);
        cyc(1, 9'h055, 1, {1'b0, SKP});
        cyc(1, {1'b0, SKP}, 1, SKP_SYM);
        cyc(1, 9'h11C, 1, 9'h11C);
        idle(4);
        check("R1 no errors from SKP", err, 0);
        check("R1 compared three", cmp, 4);
        check_state("R1");

        // R2/R3: random traffic
        rand_run(600, 6);
        check_state("R3 sparse errors");
        rand_run(600, 2);
        check_state("R2 dense errors");

        // R5: run reset by a match, then a full run
        cyc(0, '0, 0, '0, 1);
        for (int i = 0; i < LOSS_RUN - 1; i++) cyc(1, 9'h001, 1, 9'h002);
        cyc(1, 9'h0A5, 1, 9'h0A5);
        for (int i = 0; i < LOSS_RUN - 1; i++) cyc(1, 9'h001, 1, 9'h002);
        idle(3);
        check("R5 run below limit", lost, 0);
        cyc(1, 9'h001, 1, 9'h002);
        idle(2);
        check("R5 run at limit", lost, 1);

        // R7: sticky, then clear beating a same-cycle compare
        for (int i = 0; i < 5; i++) cyc(1, 9'h077, 1, 9'h077);
        idle(2);
        check("R7 flag sticky", lost, 1);
        cyc(1, 9'h000, 1, 9'h0FF);
        cyc(0, '0, 0, '0, 1);
        check_state("R7 clear wins");
        check("R7 error zero", err, 0);

        // R6: overflow on the reference side
        for (int i = 0; i < DEPTH + 1; i++) cyc(1, 9'(8'h20 + i), 0, '0);
        check("R6 overflow flag", lost, 1);
        for (int i = 0; i < DEPTH; i++) cyc(0, '0, 1, 9'(8'h20 + i));
        idle(3);
        check("R6 stored kept in order", err, 0);
        check("R6 compared depth", cmp, DEPTH);
        check_state("R6");

        // R4: saturation
        cyc(0, '0, 0, '0, 1);
        for (int i = 0; i < 200; i++) cyc(1, 9'h000, 1, 9'h1FF);
        idle(3);
        check("R4 saturated", err, ERR_MAX);
        check_state("R4");

        rand_run(300, 3);
        check_state("R3 final");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule